// File: doc/BRIEF.md
# USB Dual-Role Wrapper Control Registers

This block is the register bank that sits beside a USB dual-role controller and configures the logic around it. Software reaches it over a plain 64-bit register bus. The bus has a byte address, a write strobe, write data and a combinational read-data return. The bank holds two words: a control word and a host-configuration word. Each stored field drives a dedicated output toward the PHYs, the controller core and the self-test engine.

The control word holds three software resets, the host/device mode select, PHY power enables, port disables and a self-test start bit. The self-test engine clears the start bit when it reports completion. The host-configuration word holds a bus-master enable that stalls DMA requests while it is clear. It also holds enable and polarity fields for an off-chip overcurrent pin and an off-chip port-power pin. The block converts between those pin polarities and active-high internal signals.

Top module: `usb_glue_regs`

## Requirements
- R1: After synchronous reset, the control word reads 0x0000_0000_0000_0007 and the host-configuration word reads 0. The three reset outputs are 1 and every other control output is 0.
- R2: The control word sits at offset 0x00. Its writable bits are: 0 (glue reset), 1 (host controller reset), 2 (PHY reset), 3 (mode, 1 = device), 12 (high-speed PHY power), 14 (SuperSpeed PHY power), 16 (USB2 port off), 18 (USB3 port off), 62 (self-test start) and 63 (fast-clear self-test). A write stores exactly these bits, so the mask is 0xC000_0000_0005_500F. All other bits read 0. Each stored bit drives its own output.
- R3: The host-configuration word sits at offset 0xE0. Its writable bits are: 24 (port power active-high), 25 (port power enable), 26 (overcurrent active-high), 27 (overcurrent enable) and 28 (bus-master enable). The mask is 0x0000_0000_1F00_0000, and all other bits read 0.
- R4: When the completion input is high at a clock edge, the self-test start bit is 0 after that edge. This clear wins over a software write in the same cycle, but the other fields of that write still take effect.
- R5: The fast-clear bit drives its own output and is not changed by the completion input.
- R6: Any offset other than exactly 0x00 or 0xE0 reads as zero. A write to such an offset leaves both words unchanged.
- R7: The overcurrent flag is 1 only when overcurrent detection is enabled and the pin is at its active level. The active level is high when bit 26 is set and low when it is clear. With detection disabled, the flag is 0.
- R8: With port power enabled, the pin output equals the internal request when bit 24 is set, and equals the inverted request when bit 24 is clear. With port power disabled, the pin output is 0.
- R9: The bus-master-enable output follows bit 28. The DMA stall output is 1 exactly when a DMA request is present and bit 28 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Byte offset of the access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr (combinational) |
| bist_done | input | 1 | Self-test completion pulse |
| oc_pin_in | input | 1 | Off-chip overcurrent pin, raw level |
| pp_req | input | 1 | Internal port-power request, active-high |
| dma_req | input | 1 | DMA request from the controller |
| glue_rst | output | 1 | Wrapper logic reset |
| host_rst | output | 1 | Host controller reset |
| phy_rst | output | 1 | PHY reset |
| device_mode | output | 1 | 1 = device role, 0 = host role |
| hs_phy_pwr | output | 1 | High-speed PHY power enable |
| ss_phy_pwr | output | 1 | SuperSpeed PHY power enable |
| usb2_port_off | output | 1 | USB2 port disable |
| usb3_port_off | output | 1 | USB3 port disable |
| bist_start | output | 1 | Self-test start |
| bist_fast_clear | output | 1 | Self-test zeroes memories |
| oc_flag | output | 1 | Overcurrent detected, active-high |
| pp_pin_out | output | 1 | Off-chip port-power pin level |
| bus_master_en | output | 1 | DMA master enable |
| dma_stall | output | 1 | Stall the pending DMA request |

## Verification
The bench writes all ones to each word. A design that decodes the wrong mask shows extra or missing bits on readback. It writes to near-miss offsets such as 0x01, 0x08 and 0xE4. A design that decodes only part of the address would either corrupt a real word or return nonzero data there. The self-test start bit is written in the same cycle as a completion pulse. A design that gives the write priority would leave the start output high. Every enable/polarity combination is applied to both pins, so an inverted or ignored polarity bit shows up on the flag or the pin level.

// File: rtl/usbg_pkg.sv
package usbg_pkg;

    localparam int DATA_W = 64;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] CTRL_OFS = 8'h00;
    localparam logic [ADDR_W-1:0] HCFG_OFS = 8'hE0;

    // control word bit positions
    localparam int B_RST_GLUE = 0;
    localparam int B_RST_HOST = 1;
    localparam int B_RST_PHY  = 2;
    localparam int B_DEV_MODE = 3;
    localparam int B_HS_PWR   = 12;
    localparam int B_SS_PWR   = 14;
    localparam int B_U2_OFF   = 16;
    localparam int B_U3_OFF   = 18;
    localparam int B_BIST_GO  = 62;
    localparam int B_FAST_CLR = 63;

    // host configuration word bit positions
    localparam int B_PP_HI  = 24;
    localparam int B_PP_EN  = 25;
    localparam int B_OC_HI  = 26;
    localparam int B_OC_EN  = 27;
    localparam int B_BME    = 28;

    typedef struct packed {
        logic fast_clr;
        logic bist_go;
        logic u3_off;
        logic u2_off;
        logic ss_pwr;
        logic hs_pwr;
        logic dev_mode;
        logic rst_phy;
        logic rst_host;
        logic rst_glue;
    } ctrl_t;

    typedef struct packed {
        logic bme;
        logic oc_en;
        logic oc_hi;
        logic pp_en;
        logic pp_hi;
    } hcfg_t;

    localparam ctrl_t CTRL_INIT = '{rst_phy: 1'b1, rst_host: 1'b1, rst_glue: 1'b1, default: 1'b0};
    localparam hcfg_t HCFG_INIT = '0;

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.fast_clr = w[B_FAST_CLR];
        c.bist_go  = w[B_BIST_GO];
        c.u3_off   = w[B_U3_OFF];
        c.u2_off   = w[B_U2_OFF];
        c.ss_pwr   = w[B_SS_PWR];
        c.hs_pwr   = w[B_HS_PWR];
        c.dev_mode = w[B_DEV_MODE];
        c.rst_phy  = w[B_RST_PHY];
        c.rst_host = w[B_RST_HOST];
        c.rst_glue = w[B_RST_GLUE];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[B_FAST_CLR] = c.fast_clr;
        w[B_BIST_GO]  = c.bist_go;
        w[B_U3_OFF]   = c.u3_off;
        w[B_U2_OFF]   = c.u2_off;
        w[B_SS_PWR]   = c.ss_pwr;
        w[B_HS_PWR]   = c.hs_pwr;
        w[B_DEV_MODE] = c.dev_mode;
        w[B_RST_PHY]  = c.rst_phy;
        w[B_RST_HOST] = c.rst_host;
        w[B_RST_GLUE] = c.rst_glue;
        return w;
    endfunction

    function automatic hcfg_t hcfg_from_word(input logic [DATA_W-1:0] w);
        hcfg_t h;
        h.bme   = w[B_BME];
        h.oc_en = w[B_OC_EN];
        h.oc_hi = w[B_OC_HI];
        h.pp_en = w[B_PP_EN];
        h.pp_hi = w[B_PP_HI];
        return h;
    endfunction

    function automatic logic [DATA_W-1:0] hcfg_to_word(input hcfg_t h);
        logic [DATA_W-1:0] w;
        w = '0;
        w[B_BME]   = h.bme;
        w[B_OC_EN] = h.oc_en;
        w[B_OC_HI] = h.oc_hi;
        w[B_PP_EN] = h.pp_en;
        w[B_PP_HI] = h.pp_hi;
        return w;
    endfunction

endpackage

// File: rtl/usbg_ctrl_reg.sv
module usbg_ctrl_reg
    import usbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              bist_done,
    output ctrl_t             q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= CTRL_INIT;
        end else begin
            if (wr_en) begin
                q <= ctrl_from_word(wdata);
            end
            // completion overrides a same-cycle software write of the start bit
            if (bist_done) begin
                q.bist_go <= 1'b0;
            end
        end
    end

    p_bist_clear_r4: assert property (@(posedge clk) disable iff (rst)
        bist_done |=> !q.bist_go);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (q.rst_glue && q.rst_host && q.rst_phy && !q.bist_go && !q.dev_mode));

    p_fastclr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(q.fast_clr));

endmodule

// File: rtl/usbg_hcfg_reg.sv
module usbg_hcfg_reg
    import usbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output hcfg_t             q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= HCFG_INIT;
        end else if (wr_en) begin
            q <= hcfg_from_word(wdata);
        end
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(q));

endmodule

// File: rtl/usbg_pol_adapt.sv
// Converts between an off-chip level and an active-high internal signal.
// Disabled: output forced low.
module usbg_pol_adapt (
    input  logic en,
    input  logic active_high,
    input  logic level_in,
    output logic level_out
);

    always_comb begin
        level_out = en & (active_high ? level_in : ~level_in);
    end

    // R7 / R8: a disabled path never asserts
    always_comb begin
        if (!en) begin
            p_off_quiet_r7: assert (!level_out);
        end
    end

endmodule

// File: rtl/usb_glue_regs.sv
module usb_glue_regs
    import usbg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CTRL_ADDR = CTRL_OFS,
    parameter logic [ADDR_W-1:0] HCFG_ADDR = HCFG_OFS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              bist_done,
    input  logic              oc_pin_in,
    input  logic              pp_req,
    input  logic              dma_req,
    output logic              glue_rst,
    output logic              host_rst,
    output logic              phy_rst,
    output logic              device_mode,
    output logic              hs_phy_pwr,
    output logic              ss_phy_pwr,
    output logic              usb2_port_off,
    output logic              usb3_port_off,
    output logic              bist_start,
    output logic              bist_fast_clear,
    output logic              oc_flag,
    output logic              pp_pin_out,
    output logic              bus_master_en,
    output logic              dma_stall
);

    logic  hit_ctrl, hit_hcfg;
    ctrl_t ctrl_q;
    hcfg_t hcfg_q;

    assign hit_ctrl = (reg_addr == CTRL_ADDR);
    assign hit_hcfg = (reg_addr == HCFG_ADDR);

    usbg_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_we && hit_ctrl),
        .wdata     (reg_wdata),
        .bist_done (bist_done),
        .q         (ctrl_q)
    );

    usbg_hcfg_reg u_hcfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_we && hit_hcfg),
        .wdata (reg_wdata),
        .q     (hcfg_q)
    );

    usbg_pol_adapt u_oc (
        .en          (hcfg_q.oc_en),
        .active_high (hcfg_q.oc_hi),
        .level_in    (oc_pin_in),
        .level_out   (oc_flag)
    );

    usbg_pol_adapt u_pp (
        .en          (hcfg_q.pp_en),
        .active_high (hcfg_q.pp_hi),
        .level_in    (pp_req),
        .level_out   (pp_pin_out)
    );

    always_comb begin
        reg_rdata = '0;
        if (hit_ctrl) begin
            reg_rdata = ctrl_to_word(ctrl_q);
        end else if (hit_hcfg) begin
            reg_rdata = hcfg_to_word(hcfg_q);
        end
    end

    assign glue_rst        = ctrl_q.rst_glue;
    assign host_rst        = ctrl_q.rst_host;
    assign phy_rst         = ctrl_q.rst_phy;
    assign device_mode     = ctrl_q.dev_mode;
    assign hs_phy_pwr      = ctrl_q.hs_pwr;
    assign ss_phy_pwr      = ctrl_q.ss_pwr;
    assign usb2_port_off   = ctrl_q.u2_off;
    assign usb3_port_off   = ctrl_q.u3_off;
    assign bist_start      = ctrl_q.bist_go;
    assign bist_fast_clear = ctrl_q.fast_clr;
    assign bus_master_en   = hcfg_q.bme;
    assign dma_stall       = dma_req & ~hcfg_q.bme;

    p_unmapped_wr_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !hit_ctrl && !hit_hcfg && !bist_done) |=> ($stable(ctrl_q) && $stable(hcfg_q)));

    p_dma_stall_r9: assert property (@(posedge clk) disable iff (rst)
        (dma_req && !bus_master_en) |-> dma_stall);

    p_no_stall_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !dma_req |-> !dma_stall);

endmodule

// File: tb/sim_usb_glue_regs.sv
module sim_usb_glue_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        bist_done = 1'b0, oc_pin_in = 1'b0, pp_req = 1'b0, dma_req = 1'b0;
    logic        glue_rst, host_rst, phy_rst, device_mode, hs_phy_pwr, ss_phy_pwr;
    logic        usb2_port_off, usb3_port_off, bist_start, bist_fast_clear;
    logic        oc_flag, pp_pin_out, bus_master_en, dma_stall;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    usb_glue_regs u0 (.*);

    typedef struct packed {
        logic [15:0] tag;
        logic [7:0]  wa;
        logic [63:0] wd;
        logic [7:0]  ra;
        logic [63:0] exp;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{"R2", 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 64'hC000_0000_0005_500F}, // R2 mask
        '{"R2", 8'h00, 64'h0,                   8'h00, 64'h0},
        '{"R3", 8'hE0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hE0, 64'h0000_0000_1F00_0000}, // R3 mask
        '{"R3", 8'hE0, 64'h0000_0000_0A00_0000, 8'hE0, 64'h0000_0000_0A00_0000},
        '{"R6", 8'h08, 64'hFFFF_FFFF_FFFF_FFFF, 8'h08, 64'h0},                   // R6 read zero
        '{"R6", 8'h08, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 64'h0},
        '{"R2", 8'h00, 64'h0000_0000_0004_1008, 8'h00, 64'h0000_0000_0004_1008},
        '{"R6", 8'hE4, 64'hFFFF_FFFF_FFFF_FFFF, 8'hE0, 64'h0000_0000_0A00_0000}, // R6 write ignored
        '{"R6", 8'h01, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 64'h0000_0000_0004_1008}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [63:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd_check("R1", 8'h00, 64'h7);
        rd_check("R1", 8'hE0, 64'h0);
        check("R1", {glue_rst, host_rst, phy_rst, device_mode, bist_start, hs_phy_pwr}, 64'b111000);

        // table walk
        foreach (VECS[i]) begin
            wr(VECS[i].wa, VECS[i].wd);
            rd_check(string'(VECS[i].tag), VECS[i].ra, VECS[i].exp);
        end

        // R2 outputs follow 0x41008: device mode, hs power, usb3 off
        check("R2", {glue_rst, host_rst, phy_rst, device_mode, hs_phy_pwr, ss_phy_pwr,
                     usb2_port_off, usb3_port_off}, 64'b00011001);

        // R4 start then completion
        wr(8'h00, 64'h4000_0000_0000_0000);
        check("R4", bist_start, 1'b1);
        @(negedge clk); bist_done = 1'b1;
        @(negedge clk); bist_done = 1'b0;
        check("R4", bist_start, 1'b0);
        rd_check("R4", 8'h00, 64'h0);

        // R4 completion beats same-cycle write; R5 fast-clear lands
        @(negedge clk);
        reg_addr = 8'h00; reg_we = 1'b1; reg_wdata = 64'hC000_0000_0000_0008; bist_done = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; bist_done = 1'b0;
        check("R4", bist_start, 1'b0);
        check("R5", {bist_fast_clear, device_mode}, 2'b11);
        @(negedge clk); bist_done = 1'b1;
        @(negedge clk); bist_done = 1'b0;
        check("R5", bist_fast_clear, 1'b1);

        // R7 overcurrent: bit27 enable, bit26 active-high
        wr(8'hE0, 64'h0C00_0000);
        oc_pin_in = 1'b1; #1; check("R7", oc_flag, 1'b1);
        oc_pin_in = 1'b0; #1; check("R7", oc_flag, 1'b0);
        wr(8'hE0, 64'h0800_0000);
        oc_pin_in = 1'b0; #1; check("R7", oc_flag, 1'b1);
        oc_pin_in = 1'b1; #1; check("R7", oc_flag, 1'b0);
        wr(8'hE0, 64'h0400_0000);
        oc_pin_in = 1'b1; #1; check("R7", oc_flag, 1'b0);
        oc_pin_in = 1'b0; #1; check("R7", oc_flag, 1'b0);

        // R8 port power: bit25 enable, bit24 active-high
        wr(8'hE0, 64'h0300_0000);
        pp_req = 1'b1; #1; check("R8", pp_pin_out, 1'b1);
        pp_req = 1'b0; #1; check("R8", pp_pin_out, 1'b0);
        wr(8'hE0, 64'h0200_0000);
        pp_req = 1'b1; #1; check("R8", pp_pin_out, 1'b0);
        pp_req = 1'b0; #1; check("R8", pp_pin_out, 1'b1);
        wr(8'hE0, 64'h0100_0000);
        pp_req = 1'b0; #1; check("R8", pp_pin_out, 1'b0);
        pp_req = 1'b1; #1; check("R8", pp_pin_out, 1'b0);

        // R9 bus master enable, bit 28
        dma_req = 1'b1; #1;
        check("R9", {bus_master_en, dma_stall}, 2'b01);
        wr(8'hE0, 64'h1000_0000);
        #1; check("R9", {bus_master_en, dma_stall}, 2'b10);
        dma_req = 1'b0; #1; check("R9", dma_stall, 1'b0);

        // R1 reset re-applied
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd_check("R1", 8'h00, 64'h7);
        rd_check("R1", 8'hE0, 64'h0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule